// File: doc/BRIEF.md
# I2C Status Interlock and Clock-Stretch Controller

This block sits between an I2C byte engine and the software-visible status registers. It keeps six sticky status flags: received-byte-pending and transmit-buffer-consumed for both the master side and the slave side, a slave own-address-match flag, and a master arbitration-lost flag. When the byte engine reaches a point where continuing would overwrite unread data or send stale data, the block requests that SCL be held low. That request stays up until software writes one to the flag that caused it.

Byte-engine events are routed to the master-side or the slave-side flags by the current master-enable state. Losing arbitration clears master enable, which puts the interface in slave mode. Software cannot set master enable again while the arbitration-lost flag is still set. The SCL hold request comes from a register. It can only rise in a cycle after SCL was seen low, so it never pulls the line down in the middle of a high phase.

Top module: `i2c_ilk_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag, `scl_hold` and `master_en` go to 0, and `slave_mode` goes to 1.
- R2: A pulse on `ev_rx_byte` sets the receive flag of the active side at the next edge. The active side is master when `master_en` is 1 (flags bit 0), and slave otherwise (flags bit 1).
- R3: If `ev_rx_byte` arrives while the active side's receive flag is already 1, `scl_hold` rises one edge later. It stays high until software clears that flag, then falls at the edge after the flag reads 0.
- R4: A pulse on `ev_tx_done` sets the transmit-consumed flag of the active side: flags bit 2 for master, bit 3 for slave.
- R5: If `ev_next_byte` arrives with `nxt_is_tx`=1 and `nxt_first`=0 while the active side's transmit-consumed flag is 1, `scl_hold` is raised until that flag is cleared. When `nxt_first`=1, no stall happens.
- R6: `ev_addr_hit` sets the address-match flag (flags bit 4). While that flag is 1, `scl_hold` is requested.
- R7: `ev_arb_lost` sets the arbitration-lost flag (flags bit 5) and clears `master_en` at the next edge, so `slave_mode` reads 1. This also holds when a software enable write arrives in the same cycle.
- R8: A write of `sw_men_wr`=1 with `sw_men_val`=1 sets `master_en` only if the arbitration-lost flag is 0. Otherwise it has no effect. A write with `sw_men_val`=0 always clears it.
- R9: Writing 1 to bit i of `sw_clr` clears flag i at the next edge. If a set event for the same flag arrives in the same cycle, the flag stays 1.
- R10: `scl_hold` rises only in the cycle after `scl_low` was 1. While `scl_low` stays 0, a pending stall does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_low | input | 1 | SCL currently observed low |
| ev_rx_byte | input | 1 | Byte loaded into the receive register |
| ev_tx_done | input | 1 | Transmit register contents shifted onto the bus |
| ev_addr_hit | input | 1 | Own slave address recognised |
| ev_arb_lost | input | 1 | Master arbitration lost |
| ev_next_byte | input | 1 | Next byte about to start |
| nxt_is_tx | input | 1 | Next byte is a transmit byte |
| nxt_first | input | 1 | Next byte is the first of its transfer |
| sw_clr | input | 6 | Write-one-to-clear strobes, one per flag |
| sw_men_wr | input | 1 | Software write to master enable |
| sw_men_val | input | 1 | Value written to master enable |
| flags | output | 6 | Status flags {arb, addr, tx_s, tx_m, rx_s, rx_m} |
| scl_hold | output | 1 | Registered request to hold SCL low |
| master_en | output | 1 | Master enable |
| slave_mode | output | 1 | Interface operating as slave |

## Verification
The bench targets four risky cases:
- **Overrun receive.** A second received byte arriving on a full flag must stall the bus. A design that simply re-set the flag would let the unread byte be overwritten without any stall.
- **First transmit byte.** A first byte sent against a stale transmit-consumed flag must go out without a stall. A design that ignores `nxt_first` would hang the first transfer.
- **Set/clear race and the arbitration lockout.** The bench drives set events and clears in the same cycle, and a master-enable write while arbitration-lost is pending. Wrong priority would either lose an event or restart the master too early.
- **SCL phase gating.** `scl_low` is held at 0 while an address match is pending. A design that does not gate the hold request on the SCL phase would assert the hold during a high phase.

// File: rtl/i2c_ilk_pkg.sv
package i2c_ilk_pkg;
  localparam int NFLAG = 6;
  localparam int NSIDE = 2;

  // flag positions; the pairs for master/slave are adjacent (master first)
  localparam int F_RXM = 0;
  localparam int F_RXS = 1;
  localparam int F_TXM = 2;
  localparam int F_TXS = 3;
  localparam int F_ADR = 4;
  localparam int F_ARB = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;
  typedef logic [NSIDE-1:0] side_vec_t;

  // one-hot select of the side that receives byte events
  function automatic side_vec_t side_sel(input logic men);
    side_vec_t s;
    s = '0;
    s[0] = men;
    s[1] = ~men;
    return s;
  endfunction

  // hardware set events mapped onto flag positions
  function automatic flag_vec_t route_sets(input logic rx, input logic tx,
                                           input logic adr, input logic arb,
                                           input logic men);
    flag_vec_t v;
    side_vec_t s;
    s = side_sel(men);
    v = '0;
    for (int i = 0; i < NSIDE; i++) begin
      v[F_RXM+i] = rx & s[i];
      v[F_TXM+i] = tx & s[i];
    end
    v[F_ADR] = adr;
    v[F_ARB] = arb;
    return v;
  endfunction

  // sticky flag update: a set wins over a same-cycle clear
  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr);
    return set | (q & ~clr);
  endfunction

  // a hold request may only rise while SCL is low
  function automatic logic hold_next(input logic stall, input logic held,
                                     input logic scl_low);
    return stall & (scl_low | held);
  endfunction
endpackage

// File: rtl/ilk_flag_bank.sv
module ilk_flag_bank
  import i2c_ilk_pkg::*;
#(
  parameter int W = NFLAG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= sticky_next(q[i], set_vec[i], clr_vec[i]);
    end
  end
endmodule

// File: rtl/ilk_stall.sv
module ilk_stall
  import i2c_ilk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  flag_vec_t       flags,
  input  logic            ev_rx,
  input  logic            ev_next,
  input  logic            nxt_tx,
  input  logic            nxt_first,
  input  logic            men,
  input  logic            scl_low,
  output side_vec_t       rx_stall,
  output side_vec_t       tx_stall,
  output logic            stall_cond,
  output logic            hold_q
);
  side_vec_t act;
  side_vec_t rx_wait_q;
  side_vec_t tx_wait_q;
  logic      tx_probe;

  assign act      = side_sel(men);
  assign tx_probe = ev_next & nxt_tx & ~nxt_first;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic rx_overrun;
    logic tx_stale;
    assign rx_overrun = ev_rx & act[s] & flags[F_RXM+s];
    assign tx_stale   = tx_probe & act[s] & flags[F_TXM+s];

    // a wait is remembered only while its flag is still unserviced
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rx_wait_q[s] <= 1'b0;
        tx_wait_q[s] <= 1'b0;
      end else begin
        rx_wait_q[s] <= rx_overrun | (rx_wait_q[s] & flags[F_RXM+s]);
        tx_wait_q[s] <= tx_stale   | (tx_wait_q[s] & flags[F_TXM+s]);
      end
    end

    assign rx_stall[s] = rx_wait_q[s] & flags[F_RXM+s];
    assign tx_stall[s] = tx_wait_q[s] & flags[F_TXM+s];
  end

  assign stall_cond = (|rx_stall) | (|tx_stall) | flags[F_ADR];

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_next(stall_cond, hold_q, scl_low);
  end
endmodule

// File: rtl/ilk_mode.sv
module ilk_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_ev,
  input  logic arb_flag,
  input  logic men_wr,
  input  logic men_val,
  output logic men_q
);
  logic men_d;

  always_comb begin
    men_d = men_q;
    if (arb_ev)                   men_d = 1'b0;
    else if (men_wr && !men_val)  men_d = 1'b0;
    else if (men_wr && !arb_flag) men_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) men_q <= 1'b0;
    else        men_q <= men_d;
  end
endmodule

// File: rtl/i2c_ilk_ctrl.sv
module i2c_ilk_ctrl
  import i2c_ilk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_low,
  input  logic             ev_rx_byte,
  input  logic             ev_tx_done,
  input  logic             ev_addr_hit,
  input  logic             ev_arb_lost,
  input  logic             ev_next_byte,
  input  logic             nxt_is_tx,
  input  logic             nxt_first,
  input  logic [NFLAG-1:0] sw_clr,
  input  logic             sw_men_wr,
  input  logic             sw_men_val,
  output logic [NFLAG-1:0] flags,
  output logic             scl_hold,
  output logic             master_en,
  output logic             slave_mode
);
  flag_vec_t set_vec;
  flag_vec_t flag_q;
  side_vec_t rx_stall;
  side_vec_t tx_stall;
  logic      stall_cond;
  logic      men_q;
  logic      hold_q;

  assign set_vec = route_sets(ev_rx_byte, ev_tx_done, ev_addr_hit,
                              ev_arb_lost, men_q);

  ilk_flag_bank #(.W(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (sw_clr),
    .q       (flag_q)
  );

  ilk_stall u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags      (flag_q),
    .ev_rx      (ev_rx_byte),
    .ev_next    (ev_next_byte),
    .nxt_tx     (nxt_is_tx),
    .nxt_first  (nxt_first),
    .men        (men_q),
    .scl_low    (scl_low),
    .rx_stall   (rx_stall),
    .tx_stall   (tx_stall),
    .stall_cond (stall_cond),
    .hold_q     (hold_q)
  );

  ilk_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_ev   (ev_arb_lost),
    .arb_flag (flag_q[F_ARB]),
    .men_wr   (sw_men_wr),
    .men_val  (sw_men_val),
    .men_q    (men_q)
  );

  assign flags      = flag_q;
  assign scl_hold   = hold_q;
  assign master_en  = men_q;
  assign slave_mode = ~men_q;
endmodule

// File: rtl/ilk_chk.sv
module ilk_chk
  import i2c_ilk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_low,
  input logic             ev_rx_byte,
  input logic             ev_arb_lost,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] set_vec,
  input logic             scl_hold,
  input logic             master_en,
  input logic             stall_cond
);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0) && !scl_hold && !master_en);

  p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte && master_en) |=> flags[F_RXM]);

  p_rx_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_byte && master_en && flags[F_RXM]) |=> stall_cond);

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_ADR] && (scl_low || scl_hold)) |=> scl_hold);

  p_arb_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> (!master_en && flags[F_ARB]));

  p_men_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_ARB] && !master_en) |=> !master_en);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  p_no_high_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(scl_low));
endmodule

bind i2c_ilk_ctrl ilk_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_low     (scl_low),
  .ev_rx_byte  (ev_rx_byte),
  .ev_arb_lost (ev_arb_lost),
  .flags       (flags),
  .set_vec     (set_vec),
  .scl_hold    (scl_hold),
  .master_en   (master_en),
  .stall_cond  (stall_cond)
);

// File: tb/tb_i2c_ilk_ctrl.sv
module tb_i2c_ilk_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_low = 1'b1;
  logic ev_rx_byte = 0, ev_tx_done = 0, ev_addr_hit = 0, ev_arb_lost = 0;
  logic ev_next_byte = 0, nxt_is_tx = 0, nxt_first = 0;
  logic [5:0] sw_clr = '0;
  logic sw_men_wr = 0, sw_men_val = 0;
  logic [5:0] flags;
  logic scl_hold, master_en, slave_mode;

  always #4 clk = ~clk;  // 125 MHz

  i2c_ilk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .scl_low(scl_low),
    .ev_rx_byte(ev_rx_byte), .ev_tx_done(ev_tx_done),
    .ev_addr_hit(ev_addr_hit), .ev_arb_lost(ev_arb_lost),
    .ev_next_byte(ev_next_byte), .nxt_is_tx(nxt_is_tx),
    .nxt_first(nxt_first), .sw_clr(sw_clr),
    .sw_men_wr(sw_men_wr), .sw_men_val(sw_men_val),
    .flags(flags), .scl_hold(scl_hold), .master_en(master_en),
    .slave_mode(slave_mode)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // expected-item queues (scoreboard)
  logic [5:0] q_f[$];
  logic       q_h[$];
  logic       q_m[$];
  string      q_t[$];

  // independent reference state
  logic [5:0] m_f = '0;
  logic [1:0] m_rw = '0, m_tw = '0;
  logic       m_h = 0, m_men = 0;

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: predict the state after the coming edge, push it, advance
  task automatic tick(input string tag);
    logic [5:0] setv, nf;
    logic [1:0] side, nrw, ntw;
    logic stall, nh, nm;
    if (!rst_n) begin
      nf = '0; nrw = '0; ntw = '0; nh = 0; nm = 0;
    end else begin
      side = {~m_men, m_men};  // bit0 master, bit1 slave
      setv = {ev_arb_lost, ev_addr_hit,
              ev_tx_done & side[1], ev_tx_done & side[0],
              ev_rx_byte & side[1], ev_rx_byte & side[0]};
      // R9: set beats clear
      nf = setv | (m_f & ~sw_clr);
      stall = m_f[4];
      for (int s = 0; s < 2; s++) begin
        stall = stall | (m_rw[s] & m_f[s]) | (m_tw[s] & m_f[2+s]);
        nrw[s] = (ev_rx_byte & side[s] & m_f[s]) | (m_rw[s] & m_f[s]);
        ntw[s] = (ev_next_byte & nxt_is_tx & ~nxt_first & side[s] & m_f[2+s])
                 | (m_tw[s] & m_f[2+s]);
      end
      nh = stall & (scl_low | m_h);
      if (ev_arb_lost)               nm = 0;
      else if (sw_men_wr && !sw_men_val) nm = 0;
      else if (sw_men_wr && !m_f[5]) nm = 1;
      else                           nm = m_men;
    end
    m_f = nf; m_rw = nrw; m_tw = ntw; m_h = nh; m_men = nm;
    q_f.push_back(nf); q_h.push_back(nh); q_m.push_back(nm); q_t.push_back(tag);
    @(negedge clk);
    ev_rx_byte = 0; ev_tx_done = 0; ev_addr_hit = 0; ev_arb_lost = 0;
    ev_next_byte = 0; nxt_is_tx = 0; nxt_first = 0;
    sw_clr = '0; sw_men_wr = 0; sw_men_val = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  // monitor: compare once per cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q_f.size() > 0) begin
        string t;
        logic [5:0] ef;
        logic eh, em;
        t = q_t.pop_front(); ef = q_f.pop_front();
        eh = q_h.pop_front(); em = q_m.pop_front();
        chk(t, "flags", {2'b0, flags}, {2'b0, ef});
        chk(t, "scl_hold", {7'b0, scl_hold}, {7'b0, eh});
        chk(t, "master_en", {7'b0, master_en}, {7'b0, em});
        chk(t, "slave_mode", {7'b0, slave_mode}, {7'b0, ~em});
      end
    end
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle("R1", 3);
    rst_n = 1;
    idle("R1", 1);
    // R2 slave receive
    ev_rx_byte = 1; tick("R2"); idle("R2", 1);
    // R3 overrun while full
    ev_rx_byte = 1; tick("R3"); idle("R3", 3);
    sw_clr[1] = 1; tick("R3"); idle("R3", 2);
    // R9 set and clear in one cycle
    ev_rx_byte = 1; sw_clr[1] = 1; tick("R9"); idle("R9", 1);
    sw_clr[1] = 1; tick("R9"); idle("R9", 1);
    // R4/R5 slave transmit
    ev_tx_done = 1; tick("R4"); idle("R4", 1);
    ev_next_byte = 1; nxt_is_tx = 1; nxt_first = 1; tick("R5"); idle("R5", 2);
    ev_next_byte = 1; nxt_is_tx = 1; tick("R5"); idle("R5", 3);
    sw_clr[3] = 1; tick("R5"); idle("R5", 2);
    // R6 address match
    ev_addr_hit = 1; tick("R6"); idle("R6", 3);
    sw_clr[4] = 1; tick("R6"); idle("R6", 2);
    // R10 no hold while SCL high
    scl_low = 0;
    ev_addr_hit = 1; tick("R10"); idle("R10", 3);
    scl_low = 1; idle("R10", 2);
    sw_clr[4] = 1; tick("R10"); idle("R10", 2);
    // master side
    sw_men_wr = 1; sw_men_val = 1; tick("R8"); idle("R8", 1);
    ev_rx_byte = 1; tick("R2"); idle("R2", 1);
    ev_rx_byte = 1; tick("R3"); idle("R3", 2);
    sw_clr[0] = 1; tick("R3"); idle("R3", 2);
    ev_tx_done = 1; tick("R4"); idle("R4", 1);
    ev_next_byte = 1; nxt_is_tx = 1; tick("R5"); idle("R5", 2);
    sw_clr[2] = 1; tick("R5"); idle("R5", 2);
    // R7 arbitration loss, R8 lockout
    ev_arb_lost = 1; tick("R7"); idle("R7", 1);
    ev_rx_byte = 1; tick("R2"); idle("R2", 1);
    sw_men_wr = 1; sw_men_val = 1; tick("R8"); idle("R8", 1);
    sw_clr[5] = 1; sw_clr[1] = 1; tick("R9"); idle("R9", 1);
    sw_men_wr = 1; sw_men_val = 1; tick("R8"); idle("R8", 1);
    ev_arb_lost = 1; sw_men_wr = 1; sw_men_val = 1; tick("R7"); idle("R7", 1);
    sw_clr[5] = 1; tick("R9");
    sw_men_wr = 1; sw_men_val = 1; tick("R8");
    sw_men_wr = 1; sw_men_val = 0; tick("R8"); idle("R8", 1);
    // R1 reset from a busy state
    ev_addr_hit = 1; ev_tx_done = 1; tick("R1");
    rst_n = 0; idle("R1", 2);
    rst_n = 1; idle("R1", 1);
    while (q_f.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule